// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock for a single-master I2C controller, working from the system clock. Two 8-bit settings set the duty cycle: one gives the length of the low phase and one gives the length of the high phase. The pin is open-drain. The block only drives a pull-low control, and a released line goes high through the external pull-up resistor.

The block reads the real level of the clock line back through a two-flop synchronizer. After it releases the line, it starts counting the high time only once the synchronized level reads high. A slave that holds the line low therefore makes the high phase longer instead of shorter. If the line stays low for longer than a programmable number of cycles, a stretch-timeout flag is raised. One-cycle strobes mark the start of each low phase and the detected rising edge, so that a byte engine can change and sample data.

The byte engine controls the generator through a run request. When the request is removed, the generator finishes its current phase, completes a low phase, and then holds the line low. When the generator is disabled, the line is released at once. Only one master may be on the bus.

Top module: `scl_clkgen`

## Requirements
- R1: After reset the generator is idle. It runs only while both `en_i` and `master_i` are 1. While either is 0, `scl_pull_o`, `fall_stb_o`, `rise_stb_o` and `stretch_to_o` are 0. Clearing either input while running releases the line on the next cycle.
- R2: With `run_i` high, each low phase keeps `scl_pull_o` at 1 for Leff+1 cycles, where Leff is the programmed low value.
- R3: The high phase lasts Heff+1 cycles, counted from the first cycle in which the synchronized sensed level is high. If the line follows the pull control immediately, `scl_pull_o` stays 0 for Heff+3 cycles, and the full period is Leff+Heff+4 cycles.
- R4: A low value below 4 is used as Leff=4, so the low phase is at least 5 cycles. A high value below 2 is used as Heff=2, so the high phase is at least 3 cycles.
- R5: While the sensed line is held low by another device, the line stays released and the high count does not start. Once the line is let go, the release continues for Heff+3 cycles, counted from the first cycle in which the line reads high.
- R6: `fall_stb_o` is 1 for exactly the first cycle of every low phase.
- R7: `rise_stb_o` is a one-cycle pulse in the first cycle after the synchronized level is seen high. If the line follows immediately, this is the fourth released cycle, at index 3 counting from 0.
- R8: When `run_i` is 0, the phase in progress runs to its end, then a full low phase follows, and then `scl_pull_o` stays 1 until `run_i` returns. The line is released on the cycle after `run_i` returns.
- R9: `stretch_to_o` is 1 while the generator waits for a high level, the synchronized level is low, and the count of such waiting cycles is at least `stretch_lim_i`. If the line stays low from the moment it is released, the flag first rises in released cycle `stretch_lim_i`, counting the first released cycle as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Generator enable |
| master_i | input | 1 | Master-mode select; must be 1 together with en_i |
| run_i | input | 1 | Run request from the byte engine; 0 holds the clock low after the low phase |
| high_cnt_i | input | 8 | High phase setting (phase = value+1 cycles, minimum 3) |
| low_cnt_i | input | 8 | Low phase setting (phase = value+1 cycles, minimum 5) |
| stretch_lim_i | input | 16 | Wait cycles allowed with the line low before the timeout flag |
| scl_sense_i | input | 1 | Sensed clock line level |
| scl_pull_o | output | 1 | 1 pulls the clock line low, 0 releases it |
| fall_stb_o | output | 1 | One-cycle strobe at the start of each low phase |
| rise_stb_o | output | 1 | One-cycle strobe after the sensed rising edge |
| stretch_to_o | output | 1 | Clock stretch timeout flag |

## Verification
The assertions check on every cycle the following rules. A low phase ends only when the period counter reaches zero. A high phase ends the same way. The counting of the high phase starts only after the synchronized line has been seen high. Each new low phase comes with its fall strobe. The rise strobe never appears while the line is pulled. Losing the enable releases the line by the next cycle. Only the bench scenarios can show the exact phase lengths for each setting, the minimum clamps, the stretch timing, the hold after `run_i` drops, and the cycle in which the timeout flag rises.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HIGH = 2'd3
  } scl_st_e;

  // smallest programmed values, giving 5-cycle low and 3-cycle high phases
  localparam int unsigned MIN_LOW_CNT  = 4;
  localparam int unsigned MIN_HIGH_CNT = 2;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= RST_VAL;
        else         ff_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/scl_period_cnt.sv
module scl_period_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;

  assign zero_o = (cnt_q == '0);

  // R2
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> (zero_o == ($past(val_i) == '0)));
endmodule

// File: rtl/scl_stretch_mon.sv
module scl_stretch_mon #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wait_low_i,
  input  logic [W-1:0] lim_i,
  output logic         to_o
);
  logic [W-1:0] wcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              wcnt_q <= '0;
    else if (!wait_low_i)     wcnt_q <= '0;
    else if (wcnt_q != '1)    wcnt_q <= wcnt_q + 1'b1;

  assign to_o = wait_low_i && (wcnt_q >= lim_i);

  // R9
  to_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_o && wait_low_i && $stable(lim_i)) |=> (to_o || !wait_low_i));
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import scl_gen_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int LIM_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             master_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  input  logic [LIM_W-1:0] stretch_lim_i,
  input  logic             scl_sense_i,
  output logic             scl_pull_o,
  output logic             fall_stb_o,
  output logic             rise_stb_o,
  output logic             stretch_to_o
);
  localparam logic [CNT_W-1:0] LOW_MIN  = CNT_W'(MIN_LOW_CNT);
  localparam logic [CNT_W-1:0] HIGH_MIN = CNT_W'(MIN_HIGH_CNT);

  scl_st_e          state_q, state_d;
  logic             pull_q, fall_q, rise_q;
  logic             fall_d, rise_d;
  logic             active, sync_hi, cnt_zero, cnt_load, wait_low;
  logic [CNT_W-1:0] load_val, low_eff, high_eff;

  assign active   = en_i && master_i;
  assign low_eff  = (low_cnt_i  < LOW_MIN)  ? LOW_MIN  : low_cnt_i;
  assign high_eff = (high_cnt_i < HIGH_MIN) ? HIGH_MIN : high_cnt_i;
  assign wait_low = (state_q == ST_WAIT) && !sync_hi;

  scl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (scl_sense_i),
    .q_o   (sync_hi)
  );

  scl_period_cnt #(.W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!active),
    .load_i(cnt_load),
    .val_i (load_val),
    .zero_o(cnt_zero)
  );

  scl_stretch_mon #(.W(LIM_W)) u_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wait_low_i(wait_low),
    .lim_i     (stretch_lim_i),
    .to_o      (stretch_to_o)
  );

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    load_val = low_eff;
    fall_d   = 1'b0;
    rise_d   = 1'b0;
    if (!active) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (run_i) begin
          state_d  = ST_LOW;
          cnt_load = 1'b1;
          fall_d   = 1'b1;
        end
        // hold low until released by run_i
        ST_LOW: if (cnt_zero && run_i) state_d = ST_WAIT;
        // detection cycle counts as first high cycle
        ST_WAIT: if (sync_hi) begin
          state_d  = ST_HIGH;
          cnt_load = 1'b1;
          load_val = high_eff - 1'b1;
          rise_d   = 1'b1;
        end
        ST_HIGH: if (cnt_zero) begin
          state_d  = ST_LOW;
          cnt_load = 1'b1;
          fall_d   = 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pull_q  <= 1'b0;
      fall_q  <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pull_q  <= (state_d == ST_LOW);
      fall_q  <= fall_d;
      rise_q  <= rise_d;
    end

  assign scl_pull_o = pull_q;
  assign fall_stb_o = fall_q;
  assign rise_stb_o = rise_q;

  // R1
  dis_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> !pull_q);
  // R2
  low_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pull_q) && $past(active)) |-> $past(cnt_zero));
  // R3
  high_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pull_q) && $past(state_q) == ST_HIGH) |-> $past(cnt_zero));
  // R5
  wait_sense_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HIGH && $past(state_q) == ST_WAIT) |-> $past(sync_hi));
  // R6
  fall_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_q) |-> fall_q);
  // R7
  rise_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_q |-> !pull_q);
endmodule

// File: tb/scl_clkgen_test.sv
module scl_clkgen_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en = 1'b0, mst = 1'b0, run = 1'b0, stretch = 1'b0;
  logic [7:0]  hcnt = 8'd2, lcnt = 8'd4;
  logic [15:0] lim = 16'd200;
  logic        sense, pull, fstb, rstb, sto;
  int          checks = 0, failures = 0;

  always #4 clk = ~clk;

  assign sense = ~pull & ~stretch;

  scl_clkgen uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .master_i(mst), .run_i(run),
    .high_cnt_i(hcnt), .low_cnt_i(lcnt), .stretch_lim_i(lim),
    .scl_sense_i(sense), .scl_pull_o(pull), .fall_stb_o(fstb),
    .rise_stb_o(rstb), .stretch_to_o(sto)
  );

  typedef struct packed {
    logic [7:0] h;
    logic [7:0] l;
    int         lo;
    int         rel;
  } vec_t;

  // settings, expected low length, expected release length
  localparam vec_t VECS [0:6] = '{
    '{8'd2,   8'd4,   5,   5},
    '{8'd0,   8'd0,   5,   5},
    '{8'd1,   8'd3,   5,   5},
    '{8'd10,  8'd20,  21,  13},
    '{8'd255, 8'd255, 256, 258},
    '{8'd3,   8'd5,   6,   6},
    '{8'd7,   8'd2,   5,   10}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_level(input logic v);
    while (pull != v) @(negedge clk);
  endtask

  task automatic measure(output int lo, output int rel, output int rp, output int fs);
    wait_level(1'b0);
    wait_level(1'b1);
    fs = int'(fstb);
    lo = 0;
    while (pull) begin lo++; @(negedge clk); end
    rel = 0; rp = -1;
    while (!pull) begin
      if (rstb) rp = rel;
      rel++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lo, rel, rp, fs, n, bad;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset pull", int'(pull), 0);
    chk("R1 reset strobes", int'(fstb | rstb | sto), 0);

    // R1 enable without master mode
    en = 1'b1; run = 1'b1; bad = 0;
    repeat (30) begin @(negedge clk); if (pull | fstb | rstb) bad++; end
    chk("R1 master bit clear", bad, 0);

    // R2 R3 R4 R6 R7 table
    mst = 1'b1;
    foreach (VECS[i]) begin
      hcnt = VECS[i].h; lcnt = VECS[i].l;
      measure(lo, rel, rp, fs);
      measure(lo, rel, rp, fs);
      chk($sformatf("R2 R4 low len vec%0d", i), lo, VECS[i].lo);
      chk($sformatf("R3 R4 release len vec%0d", i), rel, VECS[i].rel);
      chk($sformatf("R6 fall strobe vec%0d", i), fs, 1);
      chk($sformatf("R7 rise strobe pos vec%0d", i), rp, 3);
    end

    // R5 R9 stretching with timeout
    hcnt = 8'd6; lcnt = 8'd4; lim = 16'd20;
    measure(lo, rel, rp, fs);
    wait_level(1'b1);
    stretch = 1'b1;
    wait_level(1'b0);
    n = 0;
    while (!sto) begin n++; @(negedge clk); end
    chk("R9 timeout cycle", n, 20);
    chk("R5 held released", int'(pull), 0);
    stretch = 1'b0;
    n = 0;
    while (!pull) begin n++; @(negedge clk); end
    chk("R5 release after stretch", n, 9);
    chk("R9 timeout cleared", int'(sto), 0);
    lim = 16'd200;

    // R8 run drop holds low
    wait_level(1'b0);
    run = 1'b0;
    wait_level(1'b1);
    bad = 0;
    repeat (60) begin @(negedge clk); if (!pull || fstb) bad++; end
    chk("R8 hold low", bad, 0);
    run = 1'b1;
    @(negedge clk);
    chk("R8 resume release", int'(pull), 0);

    // R1 disable mid phase
    wait_level(1'b1);
    en = 1'b0;
    @(negedge clk);
    chk("R1 disable releases", int'(pull), 0);
    bad = 0;
    repeat (20) begin @(negedge clk); if (pull | fstb | rstb | sto) bad++; end
    chk("R1 stays idle", bad, 0);

    // R2 after re-enable
    hcnt = 8'd3; lcnt = 8'd9;
    en = 1'b1;
    measure(lo, rel, rp, fs);
    chk("R2 low len re-enable", lo, 10);
    chk("R3 release len re-enable", rel, 6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule